// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block holds a 64-word by 16-bit non-volatile style word array behind a three-wire serial command port: chip select, serial clock and serial data in, with one serial data-out line coming back. While chip select is high, every rising edge of the serial clock is counted as a tick. The ticks carry two lead bits, a two-bit opcode, a six-bit word address and, for commands that carry data, a 16-bit data word. The block decodes the opcode and then reads a word out serially, clears bits in one word or in all words, sets one word or all words to all ones, or switches a write-protect latch.

The pins are not wired to the outside world. The host drives them by writing one byte to a general output register, and it reads data-out back as one bit of a status byte. The rest of that status byte passes through from another source. Both the pin edges and the status byte are built from registers in the system clock domain. The serial clock is therefore a data signal, sampled by the system clock, and it has no clock tree of its own.

A write does not replace the stored word. It ANDs the new data into the word, so a write can only clear bits, and an erase is the only way to set bits back to one. After reset, the array is loaded from a content-image parameter and writes are disabled.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, word i of the array holds 16'hA500 | i for the default image, writes are disabled, data-out is 1 and the status byte reads zero until the first clock after reset.
- R2: In the output register, bit 7 is chip select, bit 6 is the serial clock and bit 4 is data-in. The status byte is registered: it equals the previous cycle's status input with bit 4 replaced by data-out.
- R3: Only a rising serial-clock edge while chip select is high counts as a tick. Holding the clock high or rewriting it high adds no tick. The bits on ticks 1-2 are ignored, ticks 3-4 carry the opcode MSB first, ticks 5 to 10 carry the address MSB first, and ticks 11 to 26 carry the data MSB first.
- R4: Opcode 2 reads a word. After tick 10, data-out is 0 (a dummy bit). After ticks 11 to 26, data-out carries bits 15 down to 0 of the addressed word. After any later tick it is 1.
- R5: Opcode 0 with address bits [5:4] = 3 enables writes, and with [5:4] = 0 it disables them. While writes are disabled, opcodes 1 and 3 and the two bulk commands change nothing.
- R6: Opcode 3 sets the addressed word to 16'hFFFF as soon as tick 10 completes the address.
- R7: Opcode 0 with address bits [5:4] = 2 sets every word to 16'hFFFF at tick 10.
- R8: Opcode 1 ANDs the 16-bit data into the addressed word at tick 26.
- R9: Opcode 0 with address bits [5:4] = 1 ANDs the 16-bit data into every word at tick 26.
- R10: Chip select low clears the tick count, ends any read with data-out 1, and drops a partly received command without changing the array.
- R11: Ticks after tick 26 in the same frame are ignored. The count does not advance and no further command runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| gpo_we | input | 1 | Write strobe for the general output register |
| gpo_wdata | input | 8 | Output register value: chip select, serial clock and data-in bits |
| stat_in | input | 8 | Status byte from the surrounding logic |
| stat_out | output | 8 | Status byte with bit 4 replaced by serial data-out |

## Verification
The embedded assertions check on every cycle that the tick count never passes 26. They also check that chip select low restores an idle count and data-out, that no array command is issued while writes are disabled, and that the status byte passes through its other bits. At the array, they check that an erase leaves ones and that a write leaves no bit set that the data had cleared. What ties these together can only be shown by the bench's serial frames. That covers the bit order of addresses and read data, the dummy bit and the tick at which each command takes effect. It also covers the AND history of a word across many writes, and the effect of aborted frames and of clock pulses that are not rising edges.

// File: rtl/mw_pkg.sv
package mw_pkg;
  localparam int MW_WORDS = 64;
  localparam int MW_DW    = 16;

  localparam logic [1:0] OP_CTRL  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_READ  = 2'd2;
  localparam logic [1:0] OP_ERASE = 2'd3;

  localparam logic [1:0] SUB_WDIS = 2'd0;
  localparam logic [1:0] SUB_WRAL = 2'd1;
  localparam logic [1:0] SUB_ERAL = 2'd2;
  localparam logic [1:0] SUB_WEN  = 2'd3;

  typedef enum logic [2:0] {
    MW_NOP,
    MW_ERASE_ONE,
    MW_ERASE_ALL,
    MW_WRITE_ONE,
    MW_WRITE_ALL
  } mw_cmd_e;

  function automatic logic [MW_WORDS-1:0][MW_DW-1:0] default_image();
    logic [MW_WORDS-1:0][MW_DW-1:0] img;
    for (int i = 0; i < MW_WORDS; i++)
      img[i] = MW_DW'(16'hA500) | MW_DW'(i);
    return img;
  endfunction
endpackage

// File: rtl/mw_host_port.sv
module mw_host_port #(
  parameter int CS_BIT = 7,
  parameter int SK_BIT = 6,
  parameter int DI_BIT = 4,
  parameter int DO_BIT = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gpo_we,
  input  logic [7:0] gpo_wdata,
  input  logic [7:0] stat_in,
  input  logic       dout,
  output logic       cs,
  output logic       di,
  output logic       tick_en,
  output logic [7:0] stat_out
);
  logic [7:0] gpo_q;
  logic       sk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gpo_q     <= '0;
      sk_prev_q <= 1'b0;
      stat_out  <= '0;
    end else begin
      if (gpo_we) gpo_q <= gpo_wdata;
      sk_prev_q <= gpo_q[SK_BIT];
      stat_out  <= stat_in;
      stat_out[DO_BIT] <= dout;
    end
  end

  assign cs      = gpo_q[CS_BIT];
  assign di      = gpo_q[DI_BIT];
  assign tick_en = gpo_q[CS_BIT] & gpo_q[SK_BIT] & ~sk_prev_q;

  // R2: bits other than data-out follow the status input one cycle later
  p_status_pass_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((stat_out & ~(8'd1 << DO_BIT)) == ($past(stat_in) & ~(8'd1 << DO_BIT))));
  // R3: an edge is only seen once per held-high clock
  p_single_edge_r3: assert property (@(posedge clk) disable iff (rst)
    tick_en |=> !tick_en);
endmodule

// File: rtl/mw_frame.sv
module mw_frame
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          di,
  input  logic          tick_en,
  input  logic [DW-1:0] rd_word,
  output logic [AW-1:0] rd_addr,
  output mw_cmd_e       cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          dout
);
  localparam int LEAD       = 2;
  localparam int OPW        = 2;
  localparam int T_OP_END   = LEAD + OPW;
  localparam int T_ADDR_END = T_OP_END + AW;
  localparam int FRAME_LEN  = T_ADDR_END + DW;
  localparam int TW         = $clog2(FRAME_LEN + 2);

  logic [TW-1:0] tick_q, tick_n;
  logic [1:0]    op_q;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n, rd_sh_q;
  logic          wen_q, rd_act_q;
  logic [1:0]    sub_n, sub_q;

  assign tick_n  = tick_q + 1'b1;
  assign addr_n  = {addr_q[AW-2:0], di};
  assign data_n  = {data_q[DW-2:0], di};
  assign sub_n   = addr_n[AW-1:AW-2];
  assign sub_q   = addr_q[AW-1:AW-2];
  assign rd_addr = addr_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q   <= '0;
      op_q     <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_sh_q  <= '0;
      wen_q    <= 1'b0;
      rd_act_q <= 1'b0;
      dout     <= 1'b1;
      cmd_kind <= MW_NOP;
      cmd_addr <= '0;
      cmd_data <= '0;
    end else begin
      cmd_kind <= MW_NOP;
      if (!cs) begin
        tick_q   <= '0;
        rd_act_q <= 1'b0;
        dout     <= 1'b1;
      end else if (tick_en) begin
        if (tick_q == TW'(FRAME_LEN)) begin
          rd_act_q <= 1'b0;
          dout     <= 1'b1;
        end else begin
          tick_q <= tick_n;
          if (tick_n > TW'(LEAD) && tick_n <= TW'(T_OP_END))
            op_q <= {op_q[0], di};
          if (tick_n > TW'(T_OP_END) && tick_n <= TW'(T_ADDR_END))
            addr_q <= addr_n;
          if (tick_n > TW'(T_ADDR_END))
            data_q <= data_n;
          if (rd_act_q && tick_n > TW'(T_ADDR_END)) begin
            dout    <= rd_sh_q[DW-1];
            rd_sh_q <= {rd_sh_q[DW-2:0], 1'b0};
          end
          if (tick_n == TW'(T_ADDR_END)) begin
            case (op_q)
              OP_READ: begin
                rd_act_q <= 1'b1;
                rd_sh_q  <= rd_word;
                dout     <= 1'b0;
              end
              OP_ERASE: if (wen_q) begin
                cmd_kind <= MW_ERASE_ONE;
                cmd_addr <= addr_n;
              end
              OP_CTRL: begin
                case (sub_n)
                  SUB_WEN:  wen_q <= 1'b1;
                  SUB_WDIS: wen_q <= 1'b0;
                  SUB_ERAL: if (wen_q) cmd_kind <= MW_ERASE_ALL;
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
          if (tick_n == TW'(FRAME_LEN) && wen_q) begin
            if (op_q == OP_WRITE) begin
              cmd_kind <= MW_WRITE_ONE;
              cmd_addr <= addr_q;
              cmd_data <= data_n;
            end else if (op_q == OP_CTRL && sub_q == SUB_WRAL) begin
              cmd_kind <= MW_WRITE_ALL;
              cmd_data <= data_n;
            end
          end
        end
      end
    end
  end

  // R11: the tick count saturates at the frame length
  p_tick_bound_r11: assert property (@(posedge clk) disable iff (rst)
    tick_q <= TW'(FRAME_LEN));
  // R10: chip select low returns to an idle count and a high data-out
  p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !cs |=> (tick_q == '0) && dout);
  // R5: no array command leaves while writes are disabled
  p_guarded_cmd_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind != MW_NOP) |-> wen_q);
endmodule

// File: rtl/mw_array.sv
module mw_array
  import mw_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int DW    = 16,
  parameter int AW    = $clog2(WORDS),
  parameter logic [WORDS-1:0][DW-1:0] INIT_IMG = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  mw_cmd_e       cmd_kind,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_word
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= INIT_IMG[i];
    end else begin
      case (cmd_kind)
        MW_ERASE_ONE: mem[cmd_addr] <= '1;
        MW_WRITE_ONE: mem[cmd_addr] <= mem[cmd_addr] & cmd_data;
        MW_ERASE_ALL: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        MW_WRITE_ALL: for (int i = 0; i < WORDS; i++) mem[i] <= mem[i] & cmd_data;
        default: ;
      endcase
    end
  end

  assign rd_word = mem[rd_addr];

  // R6: a single-word erase leaves all ones
  p_erase_one_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == MW_ERASE_ONE) |=> (mem[$past(cmd_addr)] == '1));
  // R7: a bulk erase leaves all ones at both ends of the array
  p_erase_all_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == MW_ERASE_ALL) |=> (mem[0] == '1) && (mem[WORDS-1] == '1));
  // R8: a write never leaves a bit set that the data cleared
  p_write_and_r8: assert property (@(posedge clk) disable iff (rst)
    (cmd_kind == MW_WRITE_ONE) |=> ((mem[$past(cmd_addr)] & ~$past(cmd_data)) == '0));
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int WORDS = MW_WORDS,
  parameter int DW    = MW_DW,
  parameter logic [WORDS-1:0][DW-1:0] INIT_IMG = default_image()
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       gpo_we,
  input  logic [7:0] gpo_wdata,
  input  logic [7:0] stat_in,
  output logic [7:0] stat_out
);
  localparam int AW = $clog2(WORDS);

  logic          cs, di, tick_en, dout;
  logic [AW-1:0] rd_addr, cmd_addr;
  logic [DW-1:0] rd_word, cmd_data;
  mw_cmd_e       cmd_kind;

  mw_host_port u_port (
    .clk(clk), .rst(rst), .gpo_we(gpo_we), .gpo_wdata(gpo_wdata),
    .stat_in(stat_in), .dout(dout), .cs(cs), .di(di),
    .tick_en(tick_en), .stat_out(stat_out)
  );

  mw_frame #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst(rst), .cs(cs), .di(di), .tick_en(tick_en),
    .rd_word(rd_word), .rd_addr(rd_addr), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .dout(dout)
  );

  mw_array #(.WORDS(WORDS), .DW(DW), .AW(AW), .INIT_IMG(INIT_IMG)) u_array (
    .clk(clk), .rst(rst), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .rd_addr(rd_addr), .rd_word(rd_word)
  );
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       gpo_we = 1'b0;
  logic [7:0] gpo_wdata = '0;
  logic [7:0] stat_in = 8'h00;
  logic [7:0] stat_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [15:0] exp_mem [64];
  bit          exp_wen;

  mw_eeprom dut (.*);

  always #10 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hw(bit c, bit k, bit d);
    @(negedge clk);
    gpo_wdata = {c, k, 1'b0, d, 4'b0};
    gpo_we = 1'b1;
    @(negedge clk);
    gpo_we = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse(bit d);
    hw(1'b1, 1'b0, d);
    hw(1'b1, 1'b1, d);
  endtask

  task automatic header(logic [1:0] op, logic [5:0] a);
    hw(1'b0, 1'b0, 1'b0);
    pulse(1'b1); pulse(1'b1);
    for (int i = 1; i >= 0; i--) pulse(op[i]);
    for (int i = 5; i >= 0; i--) pulse(a[i]);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [5:0] a, logic [15:0] d, bit with_data);
    header(op, a);
    if (with_data) for (int i = 15; i >= 0; i--) pulse(d[i]);
    hw(1'b0, 1'b0, 1'b0);
  endtask

  task automatic read_word(logic [5:0] a, output logic [15:0] w, output bit dummy, output bit tail);
    header(2'd2, a);
    dummy = stat_out[4];
    for (int i = 15; i >= 0; i--) begin
      pulse(1'b0);
      w[i] = stat_out[4];
    end
    pulse(1'b0);
    tail = stat_out[4];
    hw(1'b0, 1'b0, 1'b0);
  endtask

  function automatic logic [15:0] default_word(int i);
    return 16'hA500 | 16'(i);
  endfunction

  task automatic model_op(logic [1:0] op, logic [5:0] a, logic [15:0] d);
    case (op)
      2'd1: if (exp_wen) exp_mem[a] = exp_mem[a] & d;
      2'd3: if (exp_wen) exp_mem[a] = 16'hFFFF;
      2'd0: case (a[5:4])
        2'd3: exp_wen = 1;
        2'd0: exp_wen = 0;
        2'd2: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
        default: if (exp_wen) for (int i = 0; i < 64; i++) exp_mem[i] = exp_mem[i] & d;
      endcase
      default: ;
    endcase
  endtask

  task automatic do_op(logic [1:0] op, logic [5:0] a, logic [15:0] d);
    send_cmd(op, a, d, op == 2'd1 || (op == 2'd0 && a[5:4] == 2'd1));
    model_op(op, a, d);
  endtask

  task automatic verify(string tag, logic [5:0] a);
    logic [15:0] w; bit dm, tl;
    read_word(a, w, dm, tl);
    check({tag, " word"}, w, exp_mem[a]);
    check("R4 dummy", dm, 1'b0);
    check("R4 tail", tl, 1'b1);
  endtask

  task automatic verify_all(string tag);
    for (int i = 0; i < 64; i++) verify(tag, 6'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w; bit dm, tl;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) exp_mem[i] = default_word(i);
    exp_wen = 0;
    stat_in = 8'h5A;
    repeat (3) @(negedge clk);
    check("R1 status in reset", stat_out, 8'h00);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    // R1/R2: data-out idle high replaces bit 4 of 0x5A
    check("R1 R2 idle status", stat_out, 8'h5A | 8'h10);
    stat_in = 8'hA5;
    @(negedge clk); @(negedge clk);
    check("R2 passthrough", stat_out, 8'hB5);
    verify("R1 default first", 6'd0);
    verify("R1 default last", 6'd63);

    // R5: writes disabled after reset
    do_op(2'd1, 6'd5, 16'h0000);
    do_op(2'd3, 6'd6, 16'h0000);
    verify("R5 write blocked", 6'd5);
    verify("R5 erase blocked", 6'd6);

    do_op(2'd0, 6'h30, 16'h0000);         // enable
    do_op(2'd1, 6'd5, 16'h0F0F);
    verify("R8 write and", 6'd5);
    do_op(2'd1, 6'd5, 16'hFF00);
    verify("R8 second and", 6'd5);
    do_op(2'd3, 6'd5, 16'h0000);
    verify("R6 erase word", 6'd5);

    // R10: abort a write after 20 ticks
    header(2'd1, 6'd9);
    for (int i = 0; i < 10; i++) pulse(1'b0);
    hw(1'b0, 1'b0, 1'b0);
    verify("R10 aborted write", 6'd9);

    // R3: re-writing the clock high must not add a tick
    hw(1'b0, 1'b0, 1'b0);
    pulse(1'b1); hw(1'b1, 1'b1, 1'b0); hw(1'b1, 1'b1, 1'b0);
    pulse(1'b1); pulse(1'b1); pulse(1'b0);
    for (int i = 5; i >= 0; i--) pulse(6'd12 >> i);
    dm = stat_out[4];
    for (int i = 15; i >= 0; i--) begin pulse(1'b0); w[i] = stat_out[4]; end
    hw(1'b0, 1'b0, 1'b0);
    check("R3 held clock dummy", dm, 1'b0);
    check("R3 held clock word", w, exp_mem[12]);

    // R11: extra ticks after a write frame change nothing more
    header(2'd1, 6'd20);
    for (int i = 15; i >= 0; i--) pulse(16'h3C3C >> i);
    for (int i = 0; i < 8; i++) pulse(1'b0);
    hw(1'b0, 1'b0, 1'b0);
    model_op(2'd1, 6'd20, 16'h3C3C);
    verify("R11 overrun write", 6'd20);

    do_op(2'd0, 6'h10, 16'hF7FE);
    verify_all("R9 write all");
    do_op(2'd0, 6'h20, 16'h0000);
    verify_all("R7 erase all");
    do_op(2'd0, 6'h00, 16'h0000);         // disable
    do_op(2'd0, 6'h20, 16'h0000);
    do_op(2'd1, 6'd3, 16'h0000);
    verify("R5 disabled again", 6'd3);

    for (int n = 0; n < 60; n++) begin
      logic [1:0] op; logic [5:0] a; logic [15:0] d;
      op = 2'($urandom_range(0, 3));
      a  = 6'($urandom);
      d  = 16'($urandom);
      if (op == 2'd0 && a[5:4] == 2'd2 && ($urandom_range(0, 3) != 0)) a[5:4] = 2'd3;
      if (op == 2'd2) verify("R4 random read", a);
      else begin
        do_op(op, a, d);
        verify("R8 random check", a);
      end
    end
    verify_all("R9 final image");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule